// File: doc/BRIEF.md
# Coherent Read Home Node with Data-Source Selection

This block is the home point for read traffic to a small set of cache lines shared by a few requesters. For each line it records the coherence state that every requester holds, and one presence bit for a last-level cache. When a read arrives, the block works out where the data must come from. The source is a peer cache reached by a snoop, the last-level cache, or a fetch from main memory. It then rewrites the per-requester states of that line to match what the read granted.

Requests are handled one at a time. An accepted request starts either one snoop transaction, one memory read, or nothing when the last-level cache can supply the data directly. A single-cycle response then reports the data source and the state granted to the requester. The block does not move data, and it does not model writes, evictions or retries.

Top module: `coh_home_tracker`

## Requirements
- R1: After reset every requester holds every line Invalid, no line is present in the last-level cache, `req_ready` is 1, and `snp_valid`, `mem_rd_valid` and `rsp_valid` are 0.
- R2: A ReadUnique (`req_op` = 2) to a line that no other requester holds raises `mem_rd_valid` with `mem_rd_line` equal to the line. The response then carries source 0 (memory) and grant 3 (UniqueDirty), and the requester becomes the only holder of the line.
- R3: A ReadUnique to a line held by other requesters issues one snoop of kind 1 (invalidate) whose `snp_mask` has a bit set for every other holder and never for the requester. The response carries source 2 (peer) and grant 3. Afterwards every other requester is Invalid for the line and the line is absent from the last-level cache.
- R4: A ReadShared (`req_op` = 1) to a line held by another requester issues a snoop of kind 0 (share) to exactly one holder, never to memory. That holder is the UniqueDirty one if it exists, otherwise the lowest-numbered holder. The response carries source 2 and grant 1 (SharedClean).
- R5: After a ReadShared served by a snoop, every previous holder and the requester are SharedClean (state code 1 in the encoding 0 Invalid, 1 SharedClean, 2 UniqueClean, 3 UniqueDirty).
- R6: A ReadShared served by a snoop marks the line present in the last-level cache.
- R7: A ReadOnce (`req_op` = 0) to a line present in the last-level cache answers with source 1 and grant 0, with no snoop and no memory read. The response comes in the cycle after acceptance.
- R8: A ReadOnce never records the requester as a holder and leaves every state of the line unchanged. An opcode of 3 behaves as a ReadOnce.
- R9: A ReadShared or ReadOnce with no other holder and no last-level copy falls back to a memory read and reports source 0. A ReadOnce with no last-level copy but another holder snoops one holder (same choice as R4) with kind 2 (read-once) and reports source 2.
- R10: `req_ready` is 1 only while no request is in progress. A snoop or memory read stays asserted, with stable target, kind and line, until `snp_ack` or `mem_rd_ack` is sampled high.
- R11: `rsp_valid` is high for exactly one cycle: the cycle after the acknowledging edge, or the cycle after acceptance for a last-level hit. `req_ready` returns in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_id | input | ID_W | Requesting agent number |
| req_op | input | 2 | 0 ReadOnce, 1 ReadShared, 2 ReadUnique, 3 treated as ReadOnce |
| req_line | input | IDX_W | Tracked line index |
| snp_valid | output | 1 | Snoop transaction outstanding |
| snp_mask | output | NUM_REQ | One bit per snooped requester |
| snp_kind | output | 2 | 0 share, 1 invalidate, 2 read-once |
| snp_line | output | IDX_W | Line being snooped |
| snp_ack | input | 1 | Snoop response accepted |
| mem_rd_valid | output | 1 | Memory read outstanding |
| mem_rd_line | output | IDX_W | Line being fetched |
| mem_rd_ack | input | 1 | Memory response accepted |
| rsp_valid | output | 1 | Response cycle |
| rsp_id | output | ID_W | Requester the response belongs to |
| rsp_src | output | 2 | 0 memory, 1 last-level cache, 2 peer |
| rsp_grant | output | 2 | State granted to the requester |

## Verification
Inputs are driven on the falling edge, and a request is taken at the next rising edge. The snoop or memory read is already visible at the falling edge that follows. The response shows one falling edge after the rising edge that sampled the acknowledge, or one falling edge after acceptance for a last-level hit, and `req_ready` is checked one falling edge later. The bench waits a random 0 to 3 cycles before acknowledging and checks at each of those falling edges that the snoop or read is held. A reference directory kept in the bench predicts every source, mask, kind and grant, so the line states that R5, R6 and R8 describe are checked through the snoop masks and sources of later requests.

// File: rtl/coh_pkg.sv
// Shared encodings for the coherent read home node.
// Assumes: two-bit codes everywhere; values are fixed because ports carry them.
package coh_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SC  = 2'd1,
        LS_UC  = 2'd2,
        LS_UD  = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        RD_ONCE   = 2'd0,
        RD_SHARED = 2'd1,
        RD_UNIQUE = 2'd2,
        RD_RSVD   = 2'd3
    } read_op_e;

    typedef enum logic [1:0] {
        SRC_MEM  = 2'd0,
        SRC_LLC  = 2'd1,
        SRC_PEER = 2'd2
    } data_src_e;

    typedef enum logic [1:0] {
        SNP_SHARE = 2'd0,
        SNP_INVAL = 2'd1,
        SNP_ONCE  = 2'd2
    } snoop_kind_e;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_SNOOP = 2'd1,
        HS_MEMRD = 2'd2,
        HS_RESP  = 2'd3
    } home_fsm_e;
endpackage

// File: rtl/coh_dir_store.sv
// Directory storage: per line, a 2-bit state for each requester plus a
// last-level-cache presence bit. One combinational read port, one write port.
// Assumes: the writer supplies a complete, consistent state vector for the line.
module coh_dir_store
    import coh_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       rd_line,
    output logic [2*NUM_REQ-1:0]   rd_states,
    output logic                   rd_llc,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_line,
    input  logic [2*NUM_REQ-1:0]   wr_states,
    input  logic                   wr_llc
);
    logic [2*NUM_REQ-1:0] dir_q [NUM_LINES];
    logic [NUM_LINES-1:0] llc_q;

    // Hold and update the state table; reset leaves everything Invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) dir_q[i] <= '0;
            llc_q <= '0;
        end else if (wr_en) begin
            dir_q[wr_line] <= wr_states;
            llc_q[wr_line] <= wr_llc;
        end
    end

    // Read port for the line under decision.
    assign rd_states = dir_q[rd_line];
    assign rd_llc    = llc_q[rd_line];

    // Count dirty owners and holders in the vector being written.
    int ud_cnt, hold_cnt;
    always_comb begin
        ud_cnt   = 0;
        hold_cnt = 0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (wr_states[2*i +: 2] == LS_UD)  ud_cnt++;
            if (wr_states[2*i +: 2] != LS_INV) hold_cnt++;
        end
    end

    // R3: a dirty owner is always the line's only holder.
    p_single_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ud_cnt != 0) |-> (hold_cnt == 1));
endmodule

// File: rtl/coh_source_decide.sv
// Pure combinational policy: from the line's current directory entry and the
// incoming read, chooses the data source, the snoop (if any), the granted
// state and the directory entry to write once the request completes.
// Assumes: req_id < NUM_REQ; the requester's own old state is not a data source.
module coh_source_decide
    import coh_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int ID_W    = 2
) (
    input  logic [1:0]           op,
    input  logic [ID_W-1:0]      req_id,
    input  logic [2*NUM_REQ-1:0] cur_states,
    input  logic                 cur_llc,
    output logic [1:0]           src,
    output logic [1:0]           grant,
    output logic                 snp_need,
    output logic [1:0]           snp_kind,
    output logic [NUM_REQ-1:0]   snp_mask,
    output logic [2*NUM_REQ-1:0] new_states,
    output logic                 new_llc
);
    logic [NUM_REQ-1:0] peer_hold;
    logic [NUM_REQ-1:0] peer_dirty;
    logic [NUM_REQ-1:0] pick_onehot;
    logic               any_hold;

    // Flag, per requester other than the current one, whether it holds / owns dirty.
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_peer
        assign peer_hold[g]  = (cur_states[2*g +: 2] != LS_INV) && (req_id != ID_W'(g));
        assign peer_dirty[g] = (cur_states[2*g +: 2] == LS_UD)  && (req_id != ID_W'(g));
    end
    assign any_hold = |peer_hold;

    // Choose one data-supplying peer: the dirty owner, else the lowest holder.
    always_comb begin
        logic found;
        pick_onehot = '0;
        found       = 1'b0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (!found && peer_dirty[i]) begin
                pick_onehot[i] = 1'b1;
                found          = 1'b1;
            end
        end
        for (int i = 0; i < NUM_REQ; i++) begin
            if (!found && peer_hold[i]) begin
                pick_onehot[i] = 1'b1;
                found          = 1'b1;
            end
        end
    end

    // Apply the per-opcode policy.
    always_comb begin
        src        = SRC_MEM;
        grant      = LS_INV;
        snp_need   = 1'b0;
        snp_kind   = SNP_SHARE;
        snp_mask   = '0;
        new_states = cur_states;
        new_llc    = cur_llc;
        case (op)
            RD_UNIQUE: begin
                grant   = LS_UD;
                new_llc = 1'b0;
                for (int i = 0; i < NUM_REQ; i++) new_states[2*i +: 2] = LS_INV;
                new_states[2*req_id +: 2] = LS_UD;
                if (any_hold) begin
                    snp_need = 1'b1;
                    snp_kind = SNP_INVAL;
                    snp_mask = peer_hold;
                    src      = SRC_PEER;
                end
            end
            RD_SHARED: begin
                grant = LS_SC;
                if (any_hold) begin
                    snp_need = 1'b1;
                    snp_kind = SNP_SHARE;
                    snp_mask = pick_onehot;
                    src      = SRC_PEER;
                    new_llc  = 1'b1;
                    for (int i = 0; i < NUM_REQ; i++)
                        if (peer_hold[i]) new_states[2*i +: 2] = LS_SC;
                end else if (cur_llc) begin
                    src = SRC_LLC;
                end
                new_states[2*req_id +: 2] = LS_SC;
            end
            default: begin
                if (cur_llc) begin
                    src = SRC_LLC;
                end else if (any_hold) begin
                    snp_need = 1'b1;
                    snp_kind = SNP_ONCE;
                    snp_mask = pick_onehot;
                    src      = SRC_PEER;
                end
            end
        endcase
    end
endmodule

// File: rtl/coh_home_tracker.sv
// Top of the coherent read home node. Accepts one read at a time, latches the
// policy decision taken on the directory at acceptance, runs a single snoop or
// memory read if needed, issues a one-cycle response and commits the new
// directory entry in that response cycle.
// Assumes: NUM_REQ >= 2, NUM_LINES >= 2; acks are only meaningful while the
// matching valid is high.
module coh_home_tracker
    import coh_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int NUM_LINES = 8,
    localparam int ID_W     = $clog2(NUM_REQ),
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ID_W-1:0]    req_id,
    input  logic [1:0]         req_op,
    input  logic [IDX_W-1:0]   req_line,
    output logic               snp_valid,
    output logic [NUM_REQ-1:0] snp_mask,
    output logic [1:0]         snp_kind,
    output logic [IDX_W-1:0]   snp_line,
    input  logic               snp_ack,
    output logic               mem_rd_valid,
    output logic [IDX_W-1:0]   mem_rd_line,
    input  logic               mem_rd_ack,
    output logic               rsp_valid,
    output logic [ID_W-1:0]    rsp_id,
    output logic [1:0]         rsp_src,
    output logic [1:0]         rsp_grant
);
    home_fsm_e            state_q;
    logic                 accept;
    logic [2*NUM_REQ-1:0] dir_states;
    logic                 dir_llc;

    logic [1:0]           d_src, d_grant, d_kind;
    logic                 d_snp;
    logic [NUM_REQ-1:0]   d_mask;
    logic [2*NUM_REQ-1:0] d_states;
    logic                 d_llc;

    logic [ID_W-1:0]      cur_id;
    logic [IDX_W-1:0]     cur_line;
    logic [1:0]           cur_op;
    logic [1:0]           lat_src, lat_grant, lat_kind;
    logic [NUM_REQ-1:0]   lat_mask;
    logic [2*NUM_REQ-1:0] lat_states;
    logic                 lat_llc;

    assign req_ready = (state_q == HS_IDLE);
    assign accept    = req_valid && req_ready;

    coh_dir_store #(
        .NUM_REQ   (NUM_REQ),
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_line   (req_line),
        .rd_states (dir_states),
        .rd_llc    (dir_llc),
        .wr_en     (state_q == HS_RESP),
        .wr_line   (cur_line),
        .wr_states (lat_states),
        .wr_llc    (lat_llc)
    );

    coh_source_decide #(
        .NUM_REQ (NUM_REQ),
        .ID_W    (ID_W)
    ) u_decide (
        .op         (req_op),
        .req_id     (req_id),
        .cur_states (dir_states),
        .cur_llc    (dir_llc),
        .src        (d_src),
        .grant      (d_grant),
        .snp_need   (d_snp),
        .snp_kind   (d_kind),
        .snp_mask   (d_mask),
        .new_states (d_states),
        .new_llc    (d_llc)
    );

    // Capture the request and its decision at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_id     <= '0;
            cur_line   <= '0;
            cur_op     <= '0;
            lat_src    <= '0;
            lat_grant  <= '0;
            lat_kind   <= '0;
            lat_mask   <= '0;
            lat_states <= '0;
            lat_llc    <= 1'b0;
        end else if (accept) begin
            cur_id     <= req_id;
            cur_line   <= req_line;
            cur_op     <= req_op;
            lat_src    <= d_src;
            lat_grant  <= d_grant;
            lat_kind   <= d_kind;
            lat_mask   <= d_snp ? d_mask : '0;
            lat_states <= d_states;
            lat_llc    <= d_llc;
        end
    end

    // Sequence one request: snoop or memory phase, then a single response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            case (state_q)
                HS_IDLE: begin
                    if (accept) begin
                        if (d_snp)                state_q <= HS_SNOOP;
                        else if (d_src == SRC_MEM) state_q <= HS_MEMRD;
                        else                      state_q <= HS_RESP;
                    end
                end
                HS_SNOOP: if (snp_ack)    state_q <= HS_RESP;
                HS_MEMRD: if (mem_rd_ack) state_q <= HS_RESP;
                default:                  state_q <= HS_IDLE;
            endcase
        end
    end

    // Drive the channel outputs from the phase and the latched decision.
    assign snp_valid    = (state_q == HS_SNOOP);
    assign snp_mask     = lat_mask;
    assign snp_kind     = lat_kind;
    assign snp_line     = cur_line;
    assign mem_rd_valid = (state_q == HS_MEMRD);
    assign mem_rd_line  = cur_line;
    assign rsp_valid    = (state_q == HS_RESP);
    assign rsp_id       = cur_id;
    assign rsp_src      = lat_src;
    assign rsp_grant    = lat_grant;

    // R10: exactly one of idle, snooping, fetching, responding at any time.
    p_one_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({req_ready, snp_valid, mem_rd_valid, rsp_valid}) == 1);

    // R10: an unacknowledged snoop persists unchanged.
    p_snp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_ack) |=> (snp_valid && $stable(snp_mask) && $stable(snp_kind)));

    // R10: an unacknowledged memory read persists unchanged.
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_line)));

    // R2: a memory-sourced response follows an acknowledged memory read.
    p_mem_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_src == SRC_MEM) |-> $past(mem_rd_valid && mem_rd_ack));

    // R4: a peer-sourced response follows an acknowledged snoop.
    p_peer_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_src == SRC_PEER) |-> $past(snp_valid && snp_ack));

    // R4: share and read-once snoops target a single peer.
    p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_kind != SNP_INVAL) |-> ($countones(snp_mask) == 1));

    // R3: the requester is never among the snoop targets.
    p_no_self_snoop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !snp_mask[rsp_id]);

    // R7: a last-level hit answers in the cycle after acceptance.
    p_llc_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_src == SRC_LLC) |-> $past(req_valid && req_ready));

    // R8: a read-once response never grants a state.
    p_once_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (cur_op == RD_ONCE || cur_op == RD_RSVD)) |-> (rsp_grant == LS_INV));

    // R11: the response lasts one cycle and ready returns right after.
    p_ready_back_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));
endmodule

// File: tb/sim_coh_home_tracker.sv
// Self-checking bench: directed scenario followed by seeded random reads,
// every outcome predicted by a reference directory kept in the bench.
module sim_coh_home_tracker;
    localparam int NR = 4;
    localparam int NL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_id = '0;
    logic [1:0] req_op = '0;
    logic [2:0] req_line = '0;
    logic       snp_valid;
    logic [3:0] snp_mask;
    logic [1:0] snp_kind;
    logic [2:0] snp_line;
    logic       snp_ack = 1'b0;
    logic       mem_rd_valid;
    logic [2:0] mem_rd_line;
    logic       mem_rd_ack = 1'b0;
    logic       rsp_valid;
    logic [1:0] rsp_id;
    logic [1:0] rsp_src;
    logic [1:0] rsp_grant;

    int n_cmp = 0;
    int n_bad = 0;
    int ref_st [NL][NR];
    bit ref_llc [NL];

    always #5 clk = ~clk;

    coh_home_tracker #(.NUM_REQ(NR), .NUM_LINES(NL)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_op(req_op), .req_line(req_line),
        .snp_valid(snp_valid), .snp_mask(snp_mask), .snp_kind(snp_kind),
        .snp_line(snp_line), .snp_ack(snp_ack),
        .mem_rd_valid(mem_rd_valid), .mem_rd_line(mem_rd_line), .mem_rd_ack(mem_rd_ack),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_src(rsp_src), .rsp_grant(rsp_grant)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Predict and check one read, then update the reference directory.
    task automatic run_req(input int id, input int op, input int line, input string tag);
        int hmask = 0, srci = -1, dirti = -1, eop;
        int path, e_src, e_grant, e_mask = 0, e_kind = 0, dly;
        for (int r = 0; r < NR; r++) begin
            if (r != id && ref_st[line][r] != 0) begin
                hmask |= (1 << r);
                if (srci < 0) srci = r;
                if (ref_st[line][r] == 3 && dirti < 0) dirti = r;
            end
        end
        if (dirti >= 0) srci = dirti;
        eop = (op == 3) ? 0 : op;
        // path: 0 snoop, 1 memory, 2 last-level
        if (eop == 2) begin
            e_grant = 3;
            if (hmask != 0) begin path = 0; e_kind = 1; e_mask = hmask; e_src = 2; end
            else begin path = 1; e_src = 0; end
        end else if (eop == 1) begin
            e_grant = 1;
            if (hmask != 0) begin path = 0; e_kind = 0; e_mask = 1 << srci; e_src = 2; end
            else if (ref_llc[line]) begin path = 2; e_src = 1; end
            else begin path = 1; e_src = 0; end
        end else begin
            e_grant = 0;
            if (ref_llc[line]) begin path = 2; e_src = 1; end
            else if (hmask != 0) begin path = 0; e_kind = 2; e_mask = 1 << srci; e_src = 2; end
            else begin path = 1; e_src = 0; end
        end

        @(negedge clk);
        req_valid = 1'b1; req_id = 2'(id); req_op = 2'(op); req_line = 3'(line);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R10 ready low while busy"}, int'(req_ready), 0);
        if (path != 2) begin
            dly = $urandom_range(0, 3);
            for (int k = 0; k <= dly; k++) begin
                if (k != 0) @(negedge clk);
                if (path == 0) begin
                    chk({tag, " R10 snp_valid"}, int'(snp_valid), 1);
                    chk({tag, " R3/R4 snp_mask"}, int'(snp_mask), e_mask);
                    chk({tag, " R9 snp_kind"}, int'(snp_kind), e_kind);
                    chk({tag, " R4 no memory read"}, int'(mem_rd_valid), 0);
                end else begin
                    chk({tag, " R2 mem_rd_valid"}, int'(mem_rd_valid), 1);
                    chk({tag, " R2 mem_rd_line"}, int'(mem_rd_line), line);
                    chk({tag, " R9 no snoop"}, int'(snp_valid), 0);
                end
            end
            if (path == 0) snp_ack = 1'b1; else mem_rd_ack = 1'b1;
            @(posedge clk);
            @(negedge clk);
            snp_ack = 1'b0; mem_rd_ack = 1'b0;
        end
        chk({tag, " R11 rsp_valid"}, int'(rsp_valid), 1);
        chk({tag, " R11 rsp_id"}, int'(rsp_id), id);
        chk({tag, " R7 rsp_src"}, int'(rsp_src), e_src);
        chk({tag, " R5 rsp_grant"}, int'(rsp_grant), e_grant);
        if (path == 2) chk({tag, " R7 no snoop"}, int'(snp_valid), 0);
        @(negedge clk);
        chk({tag, " R11 ready back"}, int'(req_ready), 1);
        chk({tag, " R11 single-cycle rsp"}, int'(rsp_valid), 0);

        if (eop == 2) begin
            for (int r = 0; r < NR; r++) ref_st[line][r] = 0;
            ref_st[line][id] = 3;
            ref_llc[line] = 1'b0;
        end else if (eop == 1) begin
            if (hmask != 0) begin
                for (int r = 0; r < NR; r++) if ((hmask >> r) & 1) ref_st[line][r] = 1;
                ref_llc[line] = 1'b1;
            end
            ref_st[line][id] = 1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int l = 0; l < NL; l++) begin
            ref_llc[l] = 1'b0;
            for (int r = 0; r < NR; r++) ref_st[l][r] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset req_ready", int'(req_ready), 1);
        chk("R1 reset snp_valid", int'(snp_valid), 0);
        chk("R1 reset mem_rd_valid", int'(mem_rd_valid), 0);
        chk("R1 reset rsp_valid", int'(rsp_valid), 0);

        run_req(2, 2, 3, "R2 unique from memory");
        run_req(3, 1, 3, "R4 shared from owner");
        run_req(1, 0, 3, "R6 once from llc");
        run_req(0, 2, 3, "R5 unique invalidates sharers");
        run_req(2, 3, 3, "R8 opcode3 once via peer");
        run_req(1, 2, 3, "R8 once left no holder");
        run_req(1, 1, 5, "R9 shared fallback");
        run_req(0, 0, 6, "R9 once fallback");
        run_req(0, 0, 6, "R1 line still empty");
        run_req(3, 1, 5, "R4 shared lowest holder");
        run_req(2, 1, 5, "R4 shared two holders");

        for (int n = 0; n < 300; n++)
            run_req($urandom_range(0, NR-1), $urandom_range(0, 3),
                    $urandom_range(0, NL-1), "R3 random");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule